// File: doc/BRIEF.md
# Latched Motor Fault Detector and Encoder

This block watches a two-phase stepper power stage for three kinds of trouble: a motor lead that has come loose, a winding or lead short that drives the current too high, and a hot substrate. Each kind of trouble is caught once, stored in a latch, and from then on every drive output is forced low until the whole block is reset. The stored state is reported in two ways. One output is a single active-low flag that goes low for any stored fault. A two-bit code names the kind of fault and takes the place of a pin that would carry one of three analog voltages.

The loose-lead check uses the fact that a connected winding pushes negative flyback current into its partner phase while the chopper is off. For each phase pair the block counts back-to-back off windows in which no such current appeared. When the count reaches a programmable limit, the open-lead fault is stored. A single window that does show negative current clears the count. A mask input switches this check off. The overcurrent comparator is ignored while the chopper blanking signal marks the no-detection interval at the start of each PWM period. The over-temperature flag is stored as soon as it is seen. All inputs are taken to be synchronous to the block clock.

Top module: `motor_fault_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), fault_n_o is 1, fault_code_o is 00, and drive_o equals drive_req_i for every request pattern.
- R2: An overcurrent comparator flag sampled high at a clock edge while blank_i is low stores the overcurrent fault. From that edge on, fault_code_o is 10 and fault_n_o is 0.
- R3: An overcurrent comparator flag that is high while blank_i is high has no effect. The code stays 00 and the flag stays 1.
- R4: An over-temperature flag sampled high at a clock edge stores the overheat fault. From that edge on, fault_code_o is 11.
- R5: For each phase pair, an off window is the run of cycles in which that pair's off_win_i bit is high. The window is judged at the first edge that samples the bit low. If the pair's count of consecutive windows with no neg_cur_i reaches open_limit_i, the open-lead fault is stored and fault_code_o becomes 01 at that edge.
- R6: An off window in which neg_cur_i of that pair is seen high in at least one cycle resets that pair's count to zero.
- R7: While open_mask_i is high, no open-lead fault is stored and the counts are held at zero. After the mask is released, counting starts again from zero.
- R8: When several faults are stored, fault_code_o shows the highest code: overheat 11 over overcurrent 10 over open 01.
- R9: While any fault is stored, every bit of drive_o is 0 and fault_n_o is 0, whatever drive_req_i is.
- R10: A stored fault stays stored when its cause goes away. Only a reset clears it.
- R11: An open_limit_i of 0 acts as a limit of 1.
- R12: Each phase pair is checked on its own. A missing flyback on either pair can trip the open-lead fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset. It also stands in for the power-on reset. |
| drive_req_i | input | 2*NUM_PAIRS (4) | Gate requests from the phase sequencer |
| blank_i | input | 1 | High during the no-detection interval at the start of each PWM period |
| oc_cmp_i | input | 1 | Overcurrent comparator flag |
| ot_flag_i | input | 1 | Over-temperature flag |
| off_win_i | input | NUM_PAIRS (2) | Per phase pair, high during the PWM off period |
| neg_cur_i | input | NUM_PAIRS (2) | Per phase pair, negative flyback current seen in the partner phase |
| open_mask_i | input | 1 | Turns off open-lead detection |
| open_limit_i | input | CNT_W (4) | Number of consecutive windows without flyback needed to trip the open-lead fault |
| drive_o | output | 2*NUM_PAIRS (4) | Gate outputs, forced to 0 while a fault is stored |
| fault_n_o | output | 1 | Active-low flag for any stored fault |
| fault_code_o | output | 2 | 00 none, 01 open lead, 10 overcurrent, 11 overheat |

## Verification
A wrong internal state shows at the ports quickly. If a latch bit is dropped, drive_o comes back to life in the cycle after the loss while the cause is already gone, so a check made several cycles after the trigger catches it. If a miss counter is off by one, or is not cleared by a flyback window or by the mask, the 01 code appears one window too early or too late. That shows at the edge that closes the window, and the bench sweeps every limit from 0 to 5 on both pairs to expose it. If the priority is wrong, the code shown after a second fault is stored is wrong.

// File: rtl/mfd_pkg.sv
// Shared definitions for the motor fault detector.
// Assumes: three fault kinds, with priority given by the numeric code value.
package mfd_pkg;

    typedef enum logic [1:0] {
        FC_NONE     = 2'b00,
        FC_OPEN     = 2'b01,
        FC_OVERCUR  = 2'b10,
        FC_OVERHEAT = 2'b11
    } fault_code_e;

    localparam int NUM_KINDS  = 3;
    localparam int IDX_OPEN   = 0;
    localparam int IDX_OC     = 1;
    localparam int IDX_OT     = 2;

endpackage

// File: rtl/mfd_open_det.sv
// Open-lead detector for one phase pair.
// Records whether negative flyback current appeared during an off window.
// At the first cycle after the window it counts windows without flyback,
// and it pulses open_hit_o when that count reaches the (non-zero) limit.
// Assumes the inputs are synchronous to clk.
module mfd_open_det #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off_win_i,
    input  logic             neg_cur_i,
    input  logic             mask_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             open_hit_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             off_q;
    logic             seen_q;
    logic [CNT_W-1:0] miss_cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] lim_eff;
    logic             win_end;

    // Derive the window-end strobe, the saturating next count and the effective limit.
    always_comb begin
        win_end = off_q & ~off_win_i;
        cnt_nxt = (miss_cnt_q == CNT_MAX) ? CNT_MAX : miss_cnt_q + CNT_ONE;
        lim_eff = (limit_i == '0) ? CNT_ONE : limit_i;
    end

    // Trip when a window without flyback brings the miss count up to the limit.
    always_comb begin
        open_hit_o = win_end & ~seen_q & ~mask_i & (cnt_nxt >= lim_eff);
    end

    // Track the window, the flyback-seen flag and the consecutive miss count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q      <= 1'b0;
            seen_q     <= 1'b0;
            miss_cnt_q <= '0;
        end else begin
            off_q <= off_win_i;
            if (mask_i) begin
                seen_q     <= 1'b0;
                miss_cnt_q <= '0;
            end else if (win_end) begin
                seen_q     <= 1'b0;
                miss_cnt_q <= seen_q ? '0 : cnt_nxt;
            end else if (off_win_i && neg_cur_i) begin
                seen_q <= 1'b1;
            end
        end
    end

    // R6
    // flyback_clears_chk
    flyback_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && seen_q && !mask_i) |=> (miss_cnt_q == '0));

    // R7
    // mask_holds_zero_chk
    mask_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> (miss_cnt_q == '0));

    // R7
    // mask_no_trip_chk
    mask_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> !open_hit_o);

endmodule

// File: rtl/mfd_fault_latch.sv
// Sticky fault store and type encoder.
// Each kind of fault sets its own bit, and only reset clears the bits.
// The code shows the highest-priority stored kind, and the flag is active low.
// Assumes the hit inputs are single-cycle or level qualified strobes.
module mfd_fault_latch
    import mfd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_hit_i,
    input  logic                 oc_hit_i,
    input  logic                 ot_hit_i,
    output logic [NUM_KINDS-1:0] lat_o,
    output logic                 fault_n_o,
    output logic [1:0]           fault_code_o
);

    logic [NUM_KINDS-1:0] lat_q;
    logic [NUM_KINDS-1:0] hit_vec;
    fault_code_e          code;

    // Gather the hit strobes into the same bit order as the store.
    always_comb begin
        hit_vec           = '0;
        hit_vec[IDX_OPEN] = open_hit_i;
        hit_vec[IDX_OC]   = oc_hit_i;
        hit_vec[IDX_OT]   = ot_hit_i;
    end

    // Set bits on hits and hold them until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_q | hit_vec;
        end
    end

    // Encode the highest stored kind.
    always_comb begin
        if (lat_q[IDX_OT])        code = FC_OVERHEAT;
        else if (lat_q[IDX_OC])   code = FC_OVERCUR;
        else if (lat_q[IDX_OPEN]) code = FC_OPEN;
        else                      code = FC_NONE;
    end

    assign lat_o        = lat_q;
    assign fault_code_o = code;
    assign fault_n_o    = ~|lat_q;

    // R10
    // sticky_latch_chk
    sticky_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lat_q) & ~lat_q) == '0));

    // R8
    // code_flag_agree_chk
    code_flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_code_o == FC_NONE) == fault_n_o));

endmodule

// File: rtl/mfd_drive_gate.sv
// Forces every gate output low while the kill input is high.
// Assumes kill comes from the registered fault store, so it is glitch free.
module mfd_drive_gate #(
    parameter int N_OUT = 4
) (
    input  logic [N_OUT-1:0] req_i,
    input  logic             kill_i,
    output logic [N_OUT-1:0] drive_o
);

    // One AND gate per output.
    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        assign drive_o[g] = req_i[g] & ~kill_i;
    end

endmodule

// File: rtl/motor_fault_guard.sv
// Top level of the latched motor fault detector and encoder.
// Qualifies the overcurrent flag against blanking, runs one open-lead detector
// per phase pair, stores faults and gates the drive outputs.
// Assumes all inputs are synchronous to clk, and that rst_n also serves as the power-on reset.
module motor_fault_guard
    import mfd_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    parameter int CNT_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_PAIRS-1:0] drive_req_i,
    input  logic                   blank_i,
    input  logic                   oc_cmp_i,
    input  logic                   ot_flag_i,
    input  logic [NUM_PAIRS-1:0]   off_win_i,
    input  logic [NUM_PAIRS-1:0]   neg_cur_i,
    input  logic                   open_mask_i,
    input  logic [CNT_W-1:0]       open_limit_i,
    output logic [2*NUM_PAIRS-1:0] drive_o,
    output logic                   fault_n_o,
    output logic [1:0]             fault_code_o
);

    localparam int N_OUT = 2 * NUM_PAIRS;

    logic [NUM_PAIRS-1:0] pair_hit;
    logic                 open_hit;
    logic                 oc_hit;
    logic [NUM_KINDS-1:0] lat;

    // One open-lead detector per phase pair.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        mfd_open_det #(.CNT_W(CNT_W)) i_open_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .off_win_i  (off_win_i[p]),
            .neg_cur_i  (neg_cur_i[p]),
            .mask_i     (open_mask_i),
            .limit_i    (open_limit_i),
            .open_hit_o (pair_hit[p])
        );
    end

    // Combine the pair strobes, and mask overcurrent during blanking.
    always_comb begin
        open_hit = |pair_hit;
        oc_hit   = oc_cmp_i & ~blank_i;
    end

    mfd_fault_latch i_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .open_hit_i   (open_hit),
        .oc_hit_i     (oc_hit),
        .ot_hit_i     (ot_flag_i),
        .lat_o        (lat),
        .fault_n_o    (fault_n_o),
        .fault_code_o (fault_code_o)
    );

    mfd_drive_gate #(.N_OUT(N_OUT)) i_gate (
        .req_i   (drive_req_i),
        .kill_i  (|lat),
        .drive_o (drive_o)
    );

    // R9
    // drive_killed_chk
    drive_killed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n_o |-> (drive_o == '0));

    // R3
    // blank_masks_oc_chk
    blank_masks_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat[IDX_OC] && blank_i) |=> !lat[IDX_OC]);

    // R4
    // overheat_stores_chk
    overheat_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag_i |=> (fault_code_o == FC_OVERHEAT));

endmodule

// File: tb/test_motor_fault_guard.sv
module test_motor_fault_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*NP-1:0] drive_req = '0;
    logic          blank = 1'b0;
    logic          oc = 1'b0;
    logic          ot = 1'b0;
    logic [NP-1:0] offw = '0;
    logic [NP-1:0] neg = '0;
    logic          mask = 1'b0;
    logic [CW-1:0] lim = '0;
    logic [2*NP-1:0] drive;
    logic          fault_n;
    logic [1:0]    code;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    motor_fault_guard #(.NUM_PAIRS(NP), .CNT_W(CW)) i_motor_fault_guard (
        .clk(clk), .rst_n(rst_n), .drive_req_i(drive_req), .blank_i(blank),
        .oc_cmp_i(oc), .ot_flag_i(ot), .off_win_i(offw), .neg_cur_i(neg),
        .open_mask_i(mask), .open_limit_i(lim), .drive_o(drive),
        .fault_n_o(fault_n), .fault_code_o(code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; oc = 0; ot = 0; blank = 0; offw = '0; neg = '0; mask = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    // One off window on pair p, with or without flyback current in the middle cycle.
    task automatic window(input int p, input bit fly);
        offw[p] = 1'b1;
        tick(1);
        neg[p] = fly;
        tick(1);
        neg[p] = 1'b0;
        tick(1);
        offw[p] = 1'b0;
        tick(2);
    endtask

    // Any stored fault: the flag is low and every request pattern is blocked.
    task automatic chk_killed(input string req);
        chk(req, fault_n, 0);
        for (int r = 0; r < 2**(2*NP); r++) begin
            drive_req = r[2*NP-1:0];
            #1;
            chk(req, drive, 0);
        end
    endtask

    initial begin
        tick(1);
        do_reset();
        // R1: clean state passes every request pattern through
        chk("R1", fault_n, 1);
        chk("R1", code, 0);
        for (int r = 0; r < 2**(2*NP); r++) begin
            drive_req = r[2*NP-1:0];
            #1;
            chk("R1", drive, r);
        end

        // R3: overcurrent during blanking is ignored
        blank = 1; oc = 1;
        tick(3);
        chk("R3", code, 0);
        chk("R3", fault_n, 1);
        // R2: overcurrent outside blanking is stored
        blank = 0;
        tick(1);
        oc = 0;
        chk("R2", code, 2);
        chk_killed("R9");
        tick(5);
        chk("R10", code, 2);
        chk_killed("R10");

        // R4: overheat
        do_reset();
        chk("R10", code, 0);
        ot = 1;
        tick(1);
        ot = 0;
        chk("R4", code, 3);
        tick(3);
        chk("R10", code, 3);

        // R5, R11, R12: sweep the limit on both pairs
        for (int l = 0; l <= 5; l++) begin
            for (int p = 0; p < NP; p++) begin
                int eff;
                eff = (l == 0) ? 1 : l;
                do_reset();
                lim = l[CW-1:0];
                for (int w = 1; w < eff; w++) begin
                    window(p, 0);
                    chk((l == 0) ? "R11" : "R5", code, 0);
                end
                window(p, 0);
                chk((l == 0) ? "R11" : ((p == 1) ? "R12" : "R5"), code, 1);
                chk_killed("R9");
            end
        end

        // R6: a window with flyback clears the count
        do_reset();
        lim = 3;
        window(0, 0); window(0, 0); window(0, 1); window(0, 0); window(0, 0);
        chk("R6", code, 0);
        window(0, 0);
        chk("R6", code, 1);

        // R7: mask blocks detection and clears the count
        do_reset();
        lim = 2;
        mask = 1;
        window(1, 0); window(1, 0); window(1, 0); window(1, 0);
        chk("R7", code, 0);
        chk("R7", fault_n, 1);
        mask = 0;
        tick(1);
        window(1, 0);
        chk("R7", code, 0);
        window(1, 0);
        chk("R7", code, 1);

        // R8: priority as faults are added
        do_reset();
        lim = 1;
        window(0, 0);
        chk("R8", code, 1);
        oc = 1; tick(1); oc = 0;
        chk("R8", code, 2);
        ot = 1; tick(1); ot = 0;
        chk("R8", code, 3);
        do_reset();
        ot = 1; tick(1); ot = 0;
        oc = 1; tick(1); oc = 0;
        window(0, 0);
        chk("R8", code, 3);
        do_reset();
        chk("R10", code, 0);
        chk("R10", fault_n, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule